// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Channel

This block is one DMA channel. Each transfer it runs is described by a descriptor of four 32-bit words that the channel reads from memory itself. A start pulse makes the channel read its first descriptor at a table base address plus a head offset. The channel then moves the items that descriptor describes through a single memory read/write port, one read followed by one write per item. In basic mode the channel stops once that descriptor is finished. In scatter-gather mode the descriptor's link word is a byte offset from the same table base. The channel follows that link to the next descriptor, and a link of zero, which points back at the base, ends the chain.

A channel set up for memory-to-memory work moves items back to back once it is started. It takes one idle cycle after every burst of `BURST` items. A channel that serves a peripheral moves exactly one item for each accepted request and acknowledges each one. The channel has two sticky status flags, done and abort, and each is cleared by writing a 1 to it. A bus error or a misaligned descriptor makes the channel abort, and the remaining count stays visible afterwards.

Top module: `sgdma_channel`

## Requirements
- R1: After a start, the channel's first four memory accesses are word reads at `tbl_base+head_ofs`, then +4, +8 and +12. These give the control, source, destination and link words, and no data beat is issued before all four are read.
- R2: Control bits [31:16] hold the item count minus one. The channel moves that value plus one items, lowers the field by one after every item except the last, and `remain_cnt` reads 0 when the descriptor completes.
- R3: Control bits [3:2] select the item width: 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. `mem_size` carries that code on data beats and is 2 on descriptor reads. The item read from the source byte lanes is written replicated across all four write-data lanes.
- R4: Control bit 4 set holds the source address fixed, and bit 5 set holds the destination address fixed. When clear, each address advances by the item size in bytes after every item.
- R5: If the source or destination address is not a multiple of the item size, or the width code is 3, the abort flag is set after the descriptor read and no data beat is issued.
- R6: With control bit 1 clear (basic mode), the channel sets the done flag and goes idle after one descriptor. It never reads the link target.
- R7: With control bit 1 set (scatter-gather mode), a non-zero link makes the channel read the descriptor at `tbl_base+link` directly after the last write of the current one, before any further data beat. A zero link ends the chain and sets the done flag.
- R8: With `mem2mem` high, a start runs all items without requests, back to back. Exactly one cycle with no memory access follows each completed burst of `BURST` items, provided items remain.
- R9: With `mem2mem` low, the channel issues no data beat until `periph_req` is high. Each accepted request moves exactly one item, and `periph_ack` is high during that item's write.
- R10: A 1 on `done_clr` or `abort_clr` clears the matching flag. A flag being set in the same cycle as its clear wins, so the flag ends up set.
- R11: An error response on any access sets the abort flag, stops the channel with no further access, and leaves `remain_cnt` at the count of the item that failed.
- R12: `chan_rst` returns the channel to idle within one cycle, clears the count and both flags, and ends all memory activity.
- R13: A start pulse while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Synchronous channel reset |
| tbl_base | input | 32 | Descriptor table base address |
| head_ofs | input | 32 | Byte offset of the first descriptor |
| mem2mem | input | 1 | 1: memory-to-memory bursts, 0: peripheral requests |
| sw_trig | input | 1 | Start pulse |
| periph_req | input | 1 | Peripheral item request |
| periph_ack | output | 1 | Item accepted for the peripheral (write cycle) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | 0: byte, 1: half-word, 2: word |
| mem_wdata | output | 32 | Write data, item replicated on lanes |
| mem_rdata | input | 32 | Read data, same cycle as request |
| mem_err | input | 1 | Error response, same cycle as request |
| done_clr | input | 1 | Write-1 clear of the done flag |
| abort_clr | input | 1 | Write-1 clear of the abort flag |
| done_flag | output | 1 | Chain completed |
| abort_flag | output | 1 | Channel aborted |
| busy | output | 1 | Channel not idle |
| remain_cnt | output | 16 | Count field (items still to move minus one) |

## Verification
The completion of a chain can fall in the same cycle as a software clear of the done flag. The bench waits for the final item's write to appear on the memory port and raises `done_clr` for exactly that cycle. It then expects the flag to read 1 afterwards, and a later lone clear must bring it to 0. The same-cycle race between a write error and item completion is also provoked: an error is injected on a chosen destination address, and the bench then judges the write count, the abort flag and the remaining count.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  // control word field positions
  localparam int unsigned F_SG   = 1;
  localparam int unsigned F_WLO  = 2;
  localparam int unsigned F_SFIX = 4;
  localparam int unsigned F_DFIX = 5;
  localparam int unsigned F_CNT  = 16;
  localparam int unsigned CNT_W  = 32 - F_CNT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_WAIT, ST_RD, ST_WR, ST_GAP
  } st_e;

  function automatic logic [2:0] item_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic fits(input logic [1:0] lo, input logic [1:0] w);
    case (w)
      2'd0:    return 1'b1;
      2'd1:    return ~lo[0];
      2'd2:    return (lo == 2'd0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] word,
                                            input logic [1:0] lo,
                                            input logic [1:0] w);
    logic [31:0] sh;
    sh = word >> {lo, 3'b000};
    case (w)
      2'd0:    return {24'd0, sh[7:0]};
      2'd1:    return {16'd0, sh[15:0]};
      default: return sh;
    endcase
  endfunction

  function automatic logic [31:0] lane_spread(input logic [31:0] item,
                                              input logic [1:0] w);
    case (w)
      2'd0:    return {4{item[7:0]}};
      2'd1:    return {2{item[15:0]}};
      default: return item;
    endcase
  endfunction

endpackage

// File: rtl/sgdma_flag.sv
module sgdma_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (chan_rst)  flag <= 1'b0;
    else if (set)       flag <= 1'b1;
    else if (clr)       flag <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !chan_rst) |=> flag);
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set && !chan_rst) |=> !flag);
  assert_flag_rst_R12: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !flag);
endmodule

// File: rtl/sgdma_addr_gen.sv
module sgdma_addr_gen
  import sgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        ld_src,
  input  logic        ld_dst,
  input  logic [31:0] ld_val,
  input  logic        step,
  input  logic [1:0]  width,
  input  logic        sfix,
  input  logic        dfix,
  output logic [31:0] src_addr,
  output logic [31:0] dst_addr
);
  logic [31:0] inc;
  assign inc = {29'd0, item_bytes(width)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
    end else if (clr) begin
      src_addr <= '0;
      dst_addr <= '0;
    end else begin
      if (ld_src)             src_addr <= ld_val;
      else if (step && !sfix) src_addr <= src_addr + inc;
      if (ld_dst)             dst_addr <= ld_val;
      else if (step && !dfix) dst_addr <= dst_addr + inc;
    end
  end

  assert_src_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sfix && !clr && !ld_src) |=> $stable(src_addr));
  assert_dst_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dfix && !clr && !ld_dst) |=> $stable(dst_addr));
  assert_src_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sfix && !clr && !ld_src) |=>
      (src_addr == $past(src_addr) + {29'd0, item_bytes($past(width))}));
endmodule

// File: rtl/sgdma_fsm.sv
module sgdma_fsm
  import sgdma_pkg::*;
#(
  parameter int unsigned BURST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_rst,
  input  logic [31:0]      tbl_base,
  input  logic [31:0]      head_ofs,
  input  logic             mem2mem,
  input  logic             sw_trig,
  input  logic             periph_req,
  output logic             periph_ack,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [1:0]       mem_size,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_err,
  input  logic [31:0]      src_addr,
  input  logic [31:0]      dst_addr,
  output logic             ld_src,
  output logic             ld_dst,
  output logic             step,
  output logic [1:0]       width,
  output logic             sfix,
  output logic             dfix,
  output logic             done_set,
  output logic             abort_set,
  output logic             busy,
  output logic [CNT_W-1:0] remain_cnt
);
  localparam int unsigned BW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [BW-1:0] BLAST = BW'(BURST - 1);

  st_e              st_q;
  logic [1:0]       widx_q;
  logic [31:0]      desc_q, nxt_q, data_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sg_q;
  logic [BW-1:0]    burst_q;

  // named internal events
  logic bus_err, align_bad, item_done, last_item, more_desc, chain_done;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_size  = 2'd2;
    mem_wdata = '0;
    case (st_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + {28'd0, widx_q, 2'b00};
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_addr;
        mem_size = width;
      end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_addr;
        mem_size  = width;
        mem_wdata = lane_spread(data_q, width);
      end
      default: ;
    endcase
  end

  assign bus_err    = mem_req && mem_err;
  assign align_bad  = (st_q == ST_CHECK) &&
                      !(fits(src_addr[1:0], width) && fits(dst_addr[1:0], width));
  assign item_done  = (st_q == ST_WR) && !mem_err;
  assign last_item  = item_done && (cnt_q == '0);
  assign more_desc  = sg_q && (nxt_q != '0);
  assign chain_done = last_item && !more_desc;

  assign ld_src     = (st_q == ST_FETCH) && (widx_q == 2'd1) && !mem_err;
  assign ld_dst     = (st_q == ST_FETCH) && (widx_q == 2'd2) && !mem_err;
  assign step       = item_done;
  assign periph_ack = (st_q == ST_WR) && !mem2mem;
  assign done_set   = chain_done && !chan_rst;
  assign abort_set  = (bus_err || align_bad) && !chan_rst;
  assign busy       = (st_q != ST_IDLE);
  assign remain_cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      widx_q  <= '0;
      desc_q  <= '0;
      nxt_q   <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      sg_q    <= 1'b0;
      width   <= '0;
      sfix    <= 1'b0;
      dfix    <= 1'b0;
      burst_q <= '0;
    end else if (chan_rst) begin
      st_q    <= ST_IDLE;
      widx_q  <= '0;
      nxt_q   <= '0;
      cnt_q   <= '0;
      sg_q    <= 1'b0;
      width   <= '0;
      sfix    <= 1'b0;
      dfix    <= 1'b0;
      burst_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (sw_trig) begin
          desc_q <= tbl_base + head_ofs;
          widx_q <= '0;
          st_q   <= ST_FETCH;
        end
        ST_FETCH: begin
          if (mem_err) st_q <= ST_IDLE;
          else begin
            widx_q <= widx_q + 2'd1;
            if (widx_q == 2'd0) begin
              cnt_q <= mem_rdata[31:F_CNT];
              sg_q  <= mem_rdata[F_SG];
              width <= mem_rdata[F_WLO+1:F_WLO];
              sfix  <= mem_rdata[F_SFIX];
              dfix  <= mem_rdata[F_DFIX];
            end
            if (widx_q == 2'd3) begin
              nxt_q <= mem_rdata;
              st_q  <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          burst_q <= '0;
          if (align_bad)    st_q <= ST_IDLE;
          else if (mem2mem) st_q <= ST_RD;
          else              st_q <= ST_WAIT;
        end
        ST_WAIT: if (periph_req) st_q <= ST_RD;
        ST_RD: begin
          if (mem_err) st_q <= ST_IDLE;
          else begin
            data_q <= lane_pick(mem_rdata, src_addr[1:0], width);
            st_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_err) st_q <= ST_IDLE;
          else if (cnt_q == '0) begin
            if (more_desc) begin
              desc_q <= tbl_base + nxt_q;
              widx_q <= '0;
              st_q   <= ST_FETCH;
            end else st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (!mem2mem) st_q <= ST_WAIT;
            else if (burst_q == BLAST) begin
              burst_q <= '0;
              st_q    <= ST_GAP;
            end else begin
              burst_q <= burst_q + BW'(1);
              st_q    <= ST_RD;
            end
          end
        end
        ST_GAP: st_q <= ST_RD;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_halt_on_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !mem_req);
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && (cnt_q != '0) && !chan_rst) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_link_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_item && more_desc && !chan_rst) |=> (mem_req && !mem_we && (widx_q == 2'd0)));
  assert_wait_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT) && !periph_req && !chan_rst) |=> !mem_req);
  assert_aligned_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (st_q == ST_RD)) |-> fits(mem_addr[1:0], mem_size));
  assert_chan_rst_R12: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (!busy && (remain_cnt == '0)));
  assert_busy_trig_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sw_trig && !chan_rst) |=> $stable(desc_q) || (st_q == ST_FETCH && widx_q == 2'd0));
endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
  import sgdma_pkg::*;
#(
  parameter int unsigned BURST = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chan_rst,
  input  logic [31:0] tbl_base,
  input  logic [31:0] head_ofs,
  input  logic        mem2mem,
  input  logic        sw_trig,
  input  logic        periph_req,
  output logic        periph_ack,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  input  logic        done_clr,
  input  logic        abort_clr,
  output logic        done_flag,
  output logic        abort_flag,
  output logic        busy,
  output logic [15:0] remain_cnt
);
  logic [31:0] src_addr, dst_addr;
  logic        ld_src, ld_dst, step, sfix, dfix, done_set, abort_set;
  logic [1:0]  width;

  sgdma_fsm #(.BURST(BURST)) u_fsm (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
    .tbl_base(tbl_base), .head_ofs(head_ofs), .mem2mem(mem2mem),
    .sw_trig(sw_trig), .periph_req(periph_req), .periph_ack(periph_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .src_addr(src_addr), .dst_addr(dst_addr),
    .ld_src(ld_src), .ld_dst(ld_dst), .step(step), .width(width),
    .sfix(sfix), .dfix(dfix), .done_set(done_set), .abort_set(abort_set),
    .busy(busy), .remain_cnt(remain_cnt)
  );

  sgdma_addr_gen u_addr (
    .clk(clk), .rst_n(rst_n), .clr(chan_rst),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_val(mem_rdata),
    .step(step), .width(width), .sfix(sfix), .dfix(dfix),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  sgdma_flag u_done (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
    .set(done_set), .clr(done_clr), .flag(done_flag)
  );

  sgdma_flag u_abort (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
    .set(abort_set), .clr(abort_clr), .flag(abort_flag)
  );
endmodule

// File: tb/sgdma_channel_bench.sv
module sgdma_channel_bench;
  localparam int BURST = 32;
  localparam logic [31:0] BASE = 32'h100;

  typedef struct packed {
    logic [1:0]  w;
    logic        sfix;
    logic        dfix;
    logic [15:0] n;
    logic [31:0] src;
    logic [31:0] dst;
    logic [7:0]  gaps;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'd2, 1'b0, 1'b0, 16'd4,  32'h200, 32'h300, 8'd0},
    '{2'd0, 1'b0, 1'b0, 16'd7,  32'h201, 32'h305, 8'd0},
    '{2'd1, 1'b0, 1'b1, 16'd5,  32'h202, 32'h310, 8'd0},
    '{2'd2, 1'b1, 1'b0, 16'd3,  32'h204, 32'h320, 8'd0},
    '{2'd0, 1'b0, 1'b0, 16'd40, 32'h200, 32'h300, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, chan_rst = 1'b0;
  logic [31:0] head_ofs = '0;
  logic mem2mem = 1'b1, sw_trig = 1'b0, periph_req = 1'b0;
  logic done_clr = 1'b0, abort_clr = 1'b0;
  logic periph_ack, mem_req, mem_we, mem_err, done_flag, abort_flag, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic [15:0] remain_cnt;

  logic [31:0] mem [256];
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  int nchk = 0, nerr = 0, cyc = 0;
  int n_acc = 0, n_wr = 0, gaps = 0, exp_n = 0;
  logic [31:0] acc_addr [512];
  logic        acc_we   [512];
  logic [31:0] exp_addr [128];
  logic [31:0] exp_data [128];
  logic [1:0]  exp_size [128];

  always #4 clk = ~clk;

  sgdma_channel #(.BURST(BURST)) u_sgdma_channel (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .tbl_base(BASE),
    .head_ofs(head_ofs), .mem2mem(mem2mem), .sw_trig(sw_trig),
    .periph_req(periph_req), .periph_ack(periph_ack), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .done_clr(done_clr), .abort_clr(abort_clr), .done_flag(done_flag),
    .abort_flag(abort_flag), .busy(busy), .remain_cnt(remain_cnt)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_err   = mem_req && err_en && (mem_addr == err_addr);

  function automatic logic [7:0] bval(input logic [31:0] a);
    return (a[7:0] * 8'd3) ^ 8'h5A ^ {a[9:8], 6'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory write with byte enables derived from size and low address bits
  always @(posedge clk) begin
    if (mem_req && mem_we && !mem_err) begin
      for (int b = 0; b < 4; b++) begin
        if ((mem_size == 2'd2) || (mem_size == 2'd1 && (b >> 1) == mem_addr[1]) ||
            (mem_size == 2'd0 && b == mem_addr[1:0]))
          mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
    end
  end

  // port monitor
  always @(negedge clk) begin
    cyc++;
    if (mem_req) begin
      if (n_acc < 512) begin
        acc_addr[n_acc] = mem_addr;
        acc_we[n_acc]   = mem_we;
      end
      n_acc++;
      if (mem_we && !mem_err) begin
        if (n_wr < exp_n) begin
          chk(mem_addr == exp_addr[n_wr], "R4 write address", mem_addr, exp_addr[n_wr]);
          chk(mem_wdata == exp_data[n_wr], "R3 write data", mem_wdata, exp_data[n_wr]);
          chk(mem_size == exp_size[n_wr], "R3 write size", {30'd0, mem_size}, {30'd0, exp_size[n_wr]});
        end else chk(1'b0, "R2 extra write", n_wr, exp_n);
        n_wr++;
      end
    end else if (busy && n_wr > 0) gaps++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic mem_init();
    for (int i = 0; i < 256; i++)
      mem[i] = {bval(4*i+3), bval(4*i+2), bval(4*i+1), bval(4*i)};
  endtask

  task automatic put_desc(input logic [31:0] a, input logic sg, input logic [1:0] w,
                          input logic sf, input logic df, input int n,
                          input logic [31:0] s, input logic [31:0] d, input logic [31:0] nx);
    mem[a[9:2]]     = {16'(n - 1), 10'd0, df, sf, w, sg, 1'b0};
    mem[a[9:2] + 1] = s;
    mem[a[9:2] + 2] = d;
    mem[a[9:2] + 3] = nx;
  endtask

  task automatic add_exp(input logic [1:0] w, input logic sf, input logic df, input int n,
                         input logic [31:0] s, input logic [31:0] d);
    int bytes;
    logic [31:0] sa, item;
    bytes = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) begin
      sa   = sf ? s : s + k * bytes;
      item = {bval(sa + 3), bval(sa + 2), bval(sa + 1), bval(sa)};
      exp_addr[exp_n] = df ? d : d + k * bytes;
      exp_size[exp_n] = w;
      exp_data[exp_n] = (w == 2'd0) ? {4{item[7:0]}} : (w == 2'd1) ? {2{item[15:0]}} : item;
      exp_n++;
    end
  endtask

  task automatic clr_logs();
    n_acc = 0; n_wr = 0; gaps = 0; exp_n = 0;
  endtask

  task automatic start(input logic [31:0] ofs);
    head_ofs = ofs; sw_trig = 1'b1;
    tick();
    sw_trig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) tick();
  endtask

  task automatic clear_flags();
    done_clr = 1'b1; abort_clr = 1'b1;
    tick();
    done_clr = 1'b0; abort_clr = 1'b0;
  endtask

  initial begin
    mem_init();
    tick(); tick();
    // reset state
    chk(!busy && !done_flag && !abort_flag, "R12 reset idle/flags", {busy, done_flag, abort_flag}, 0);
    chk(remain_cnt == 0 && !mem_req, "R12 reset count", remain_cnt, 0);
    rst_n = 1'b1;
    tick();

    // table of memory-to-memory basic transfers
    for (int v = 0; v < 5; v++) begin
      mem_init(); clr_logs();
      put_desc(BASE, 1'b0, VEC[v].w, VEC[v].sfix, VEC[v].dfix, int'(VEC[v].n),
               VEC[v].src, VEC[v].dst, 32'h0);
      add_exp(VEC[v].w, VEC[v].sfix, VEC[v].dfix, int'(VEC[v].n), VEC[v].src, VEC[v].dst);
      mem2mem = 1'b1;
      start(0);
      wait_idle();
      chk(n_wr == int'(VEC[v].n), "R2 item count", n_wr, VEC[v].n);
      chk(done_flag && !abort_flag, "R6 done after basic", {done_flag, abort_flag}, 2'b10);
      chk(remain_cnt == 0, "R2 count at end", remain_cnt, 0);
      chk(gaps == int'(VEC[v].gaps), "R8 burst gaps", gaps, VEC[v].gaps);
      if (v == 0)
        for (int i = 0; i < 4; i++)
          chk(acc_addr[i] == BASE + 4*i && !acc_we[i], "R1 descriptor read order", acc_addr[i], BASE + 4*i);
      clear_flags();
    end

    // R6: basic mode ignores a non-zero link
    mem_init(); clr_logs();
    put_desc(BASE, 1'b0, 2'd2, 1'b0, 1'b0, 2, 32'h200, 32'h300, 32'h20);
    put_desc(BASE + 32'h20, 1'b0, 2'd2, 1'b0, 1'b0, 2, 32'h210, 32'h340, 32'h0);
    add_exp(2'd2, 1'b0, 1'b0, 2, 32'h200, 32'h300);
    start(0); wait_idle();
    chk(n_acc == 8, "R6 no link fetch in basic", n_acc, 8);
    chk(done_flag, "R6 done flag", done_flag, 1);
    clear_flags();

    // R7: scatter-gather chain of two descriptors
    mem_init(); clr_logs();
    put_desc(BASE, 1'b1, 2'd2, 1'b0, 1'b0, 2, 32'h200, 32'h300, 32'h20);
    put_desc(BASE + 32'h20, 1'b1, 2'd1, 1'b0, 1'b0, 3, 32'h210, 32'h340, 32'h0);
    add_exp(2'd2, 1'b0, 1'b0, 2, 32'h200, 32'h300);
    add_exp(2'd1, 1'b0, 1'b0, 3, 32'h210, 32'h340);
    start(0); wait_idle();
    chk(n_wr == 5, "R7 chain item count", n_wr, 5);
    for (int i = 0; i < 4; i++)
      chk(acc_addr[8+i] == BASE + 32'h20 + 4*i && !acc_we[8+i], "R7 link fetch before beats",
          acc_addr[8+i], BASE + 32'h20 + 4*i);
    chk(n_acc == 18 && done_flag, "R7 zero link terminates", n_acc, 18);
    clear_flags();

    // R9: peripheral request pacing
    mem_init(); clr_logs();
    put_desc(BASE, 1'b0, 2'd1, 1'b0, 1'b1, 3, 32'h200, 32'h3F0, 32'h0);
    add_exp(2'd1, 1'b0, 1'b1, 3, 32'h200, 32'h3F0);
    mem2mem = 1'b0;
    start(0);
    for (int i = 0; i < 6; i++) tick();
    chk(n_wr == 0 && n_acc == 4, "R9 no beat without request", n_acc, 4);
    for (int r = 0; r < 3; r++) begin
      periph_req = 1'b1;
      for (int i = 0; i < 20 && !periph_ack; i++) tick();
      periph_req = 1'b0;
      tick();
      chk(n_wr == r + 1, "R9 one item per request", n_wr, r + 1);
    end
    chk(!busy && done_flag, "R9 done after last request", {busy, done_flag}, 2'b01);
    mem2mem = 1'b1;
    clear_flags();

    // R10: set and clear in the same cycle
    mem_init(); clr_logs();
    put_desc(BASE, 1'b0, 2'd2, 1'b0, 1'b0, 3, 32'h200, 32'h300, 32'h0);
    add_exp(2'd2, 1'b0, 1'b0, 3, 32'h200, 32'h300);
    start(0);
    for (int i = 0; i < 100 && n_wr < 3; i++) tick();
    done_clr = 1'b1;
    tick();
    done_clr = 1'b0;
    chk(done_flag, "R10 set wins over clear", done_flag, 1);
    done_clr = 1'b1; tick(); done_clr = 1'b0; tick();
    chk(!done_flag, "R10 write-1 clear", done_flag, 0);

    // R13: start while busy is ignored
    mem_init(); clr_logs();
    put_desc(BASE, 1'b0, 2'd2, 1'b0, 1'b0, 3, 32'h200, 32'h300, 32'h0);
    put_desc(BASE + 32'h40, 1'b0, 2'd2, 1'b0, 1'b0, 2, 32'h210, 32'h380, 32'h0);
    add_exp(2'd2, 1'b0, 1'b0, 3, 32'h200, 32'h300);
    start(0); tick(); tick();
    start(32'h40);
    wait_idle();
    chk(n_wr == 3 && n_acc == 10, "R13 busy start ignored", n_acc, 10);
    clear_flags();

    // R11: bus error on the third write
    mem_init(); clr_logs();
    put_desc(BASE, 1'b0, 2'd2, 1'b0, 1'b0, 6, 32'h200, 32'h300, 32'h0);
    add_exp(2'd2, 1'b0, 1'b0, 6, 32'h200, 32'h300);
    err_en = 1'b1; err_addr = 32'h308;
    start(0); wait_idle();
    err_en = 1'b0;
    chk(n_wr == 2, "R11 writes before error", n_wr, 2);
    chk(abort_flag && !done_flag, "R11 abort flag", {abort_flag, done_flag}, 2'b10);
    chk(remain_cnt == 3, "R11 remaining count", remain_cnt, 3);
    abort_clr = 1'b1; tick(); abort_clr = 1'b0;
    chk(!abort_flag, "R10 abort write-1 clear", abort_flag, 0);

    // R5: misaligned word source
    mem_init(); clr_logs();
    put_desc(BASE, 1'b0, 2'd2, 1'b0, 1'b0, 2, 32'h202, 32'h300, 32'h0);
    start(0); wait_idle();
    chk(n_acc == 4 && n_wr == 0, "R5 misaligned no beats", n_acc, 4);
    chk(abort_flag, "R5 misaligned abort", abort_flag, 1);

    // R12: channel reset mid-transfer (abort still set from R5)
    mem_init(); clr_logs();
    put_desc(BASE, 1'b0, 2'd0, 1'b0, 1'b0, 40, 32'h200, 32'h300, 32'h0);
    add_exp(2'd0, 1'b0, 1'b0, 40, 32'h200, 32'h300);
    start(0);
    for (int i = 0; i < 200 && n_wr < 5; i++) tick();
    chan_rst = 1'b1; tick(); chan_rst = 1'b0;
    chk(!busy && remain_cnt == 0, "R12 channel reset idle", remain_cnt, 0);
    chk(!abort_flag && !done_flag, "R12 flags cleared", {abort_flag, done_flag}, 0);
    begin
      int w0;
      w0 = n_wr;
      for (int i = 0; i < 10; i++) tick();
      chk(n_wr == w0 && !mem_req, "R12 no activity after reset", n_wr, w0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule